// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the bus-facing control core of a simple serial port. It decodes single-byte reads and writes inside a 64-byte register window and keeps the port's configuration and flag state. Two mode bytes share one offset and are reached through a pointer. A status byte and an interrupt status byte are built from the live transmitter and receiver state. An interrupt mask selects which interrupt causes drive the single level-sensitive interrupt line.

A command byte written by software carries three separate fields: a miscellaneous reset action, a transmitter action and a receiver action. The three are applied in that fixed sequence within one write. A single transmit holding byte is presented on a one-cycle valid strobe as soon as the transmitter is allowed to send. Received bytes and line-break events come in from a separate receive path on side signals and are queued in a small internal FIFO that software drains through the data offset. Baud generation, bit shifting and parity live elsewhere.

Top module: `uart_regctl`

## Requirements
- R1: Only bus_addr[5:0] is decoded. Reads: 0x00 mode byte, 0x04 status, 0x0C receive data, 0x14 interrupt status, 0x18 and 0x1C the constant divider bytes DIV_HI and DIV_LO. Any other offset reads 0. Read data is combinational in the strobe cycle; side effects occur at the next rising edge.
- R2: Offset 0x00 reads and writes the mode byte selected by a pointer (0 = first, 1 = second). Every write there stores into the selected byte and leaves the pointer at 1.
- R3: Status byte: bit0 receive data ready, bit1 receive FIFO full, bit2 transmitter enabled (ready), bit3 transmit holding byte empty; bits 7:4 read 0.
- R4: The misc field is cmd[6:4]. Value 1 returns the mode pointer to 0; 2 disables the receiver and empties the FIFO; 3 disables the transmitter and marks the holding byte empty; 5 clears the break flag. All other values do nothing.
- R5: cmd[3:2] is the transmitter field and cmd[1:0] the receiver field: 1 enables, 2 disables, 3 does nothing. Misc acts first, then transmitter, then receiver.
- R6: A write to 0x0C loads the holding byte. With the transmitter enabled, tx_valid is high for exactly the cycle after the write edge with tx_data equal to the byte, and the empty flag stays set; otherwise the empty flag clears.
- R7: A transmitter enable command while the holding byte is not empty emits it on tx_valid and sets the empty flag.
- R8: Interrupt status bit0 equals transmitter enabled; bit1 equals FIFO full when mode byte 0 bit6 is 1 and receive data ready otherwise; bit2 is the break flag. irq is high when interrupt status AND the mask (written at 0x14) is non-zero.
- R9: After reset the status is 0x08, both enables, both mode bytes, the pointer, the break flag, interrupt status and mask are zero, and irq and rx_accept are low.
- R10: rx_accept is high when the receiver is enabled and the FIFO is not full; rx_push with rx_accept enqueues rx_byte. Reads of 0x0C return bytes in arrival order and a read of an empty FIFO returns 0.
- R11: An rx_break pulse sets the break flag and enqueues a zero byte regardless of enables; if the FIFO is full it replaces the newest entry.
- R12: Writes to 0x04, 0x10 and unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; low six bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_push | input | 1 | Received byte valid from the receive path |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line-break event pulse |
| rx_accept | output | 1 | Receive path may push a byte |
| tx_valid | output | 1 | One-cycle strobe carrying a byte to send |
| tx_data | output | 8 | Byte to send, valid with tx_valid |
| irq | output | 1 | Level interrupt request |

## Verification
The command decoder is driven with packed bytes that mix fields, such as a transmitter reset combined with a transmitter enable and a flush combined with a receiver enable, which separates a correct misc-then-transmitter-then-receiver order from any other. Transmit writes are made both with the transmitter off and on, so a pending byte released by a later enable is told apart from an immediate send. The receive queue is filled to capacity and then hit by a break, which distinguishes overwriting the newest entry from dropping the event, and toggling mode bit6 in effect shows whether the receive interrupt follows FIFO full or data ready.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;
   localparam int OFS_W = 6;

   localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
   localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
   localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
   localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
   localparam logic [OFS_W-1:0] OFS_AUX  = 6'h10;
   localparam logic [OFS_W-1:0] OFS_INT  = 6'h14;
   localparam logic [OFS_W-1:0] OFS_DVH  = 6'h18;
   localparam logic [OFS_W-1:0] OFS_DVL  = 6'h1C;

   typedef enum logic [2:0] {
      MISC_NOP     = 3'd0,
      MISC_PTR_RST = 3'd1,
      MISC_RX_RST  = 3'd2,
      MISC_TX_RST  = 3'd3,
      MISC_ERR_RST = 3'd4,
      MISC_BRK_CLR = 3'd5,
      MISC_BRK_ON  = 3'd6,
      MISC_BRK_OFF = 3'd7
   } misc_e;

   typedef enum logic [1:0] {
      DIR_NOP = 2'd0,
      DIR_EN  = 2'd1,
      DIR_DIS = 2'd2,
      DIR_RSV = 2'd3
   } dir_e;

   typedef struct packed {
      misc_e misc;
      dir_e  tx;
      dir_e  rx;
   } cmd_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
   import uart_regctl_pkg::*;
(
   input  logic [7:0] cmd_byte,
   output cmd_t       cmd
);
   always_comb begin
      cmd.misc = misc_e'(cmd_byte[6:4]);
      cmd.tx   = dir_e'(cmd_byte[3:2]);
      cmd.rx   = dir_e'(cmd_byte[1:0]);
   end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              not_empty,
   output logic              full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_rxq: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] ent   [DEPTH];
   logic [DATA_W-1:0] ent_d [DEPTH];
   logic [CNT_W-1:0]  cnt, cnt_d, after_pop, widx;
   logic              pop_ok;

   assign not_empty = (cnt != '0);
   assign full      = (cnt == CNT_W'(DEPTH));
   assign head      = not_empty ? ent[0] : '0;
   assign pop_ok    = pop && not_empty;

   always_comb begin
      after_pop = cnt - CNT_W'(pop_ok);
      widx      = (after_pop == CNT_W'(DEPTH)) ? CNT_W'(DEPTH - 1) : after_pop;
      for (int i = 0; i < DEPTH; i++) begin
         if (pop_ok)
            ent_d[i] = (i < DEPTH - 1) ? ent[(i < DEPTH - 1) ? i + 1 : i] : '0;
         else
            ent_d[i] = ent[i];
         if (push && (widx == CNT_W'(i)))
            ent_d[i] = din;
      end
      if (flush)
         cnt_d = '0;
      else if (push && (after_pop != CNT_W'(DEPTH)))
         cnt_d = after_pop + 1'b1;
      else
         cnt_d = after_pop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         cnt <= cnt_d;
         for (int i = 0; i < DEPTH; i++) ent[i] <= ent_d[i];
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R10
   AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !flush && not_empty) |=> (cnt == $past(cnt) - 1'b1)); // R10
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !not_empty); // R4
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
   import uart_regctl_pkg::*;
#(
   parameter int         ADDR_W   = 8,
   parameter int         RX_DEPTH = 4,
   parameter logic [7:0] DIV_HI   = 8'h02,
   parameter logic [7:0] DIV_LO   = 8'h8B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   input  logic              rx_break,
   output logic              rx_accept,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              irq
);
   generate
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("uart_regctl: ADDR_W must cover the 64-byte window");
      end
   endgenerate

   logic [OFS_W-1:0] ofs;
   logic             wr_stb, rd_stb;
   assign ofs    = bus_addr[OFS_W-1:0];
   assign wr_stb = bus_sel && bus_wr;
   assign rd_stb = bus_sel && !bus_wr;

   logic [7:0] mode [2];
   logic       ptr, tx_en, rx_en, tx_emp, brk_flg;
   logic [7:0] tx_buf, imr;

   logic       ptr_d, tx_en_d, rx_en_d, tx_emp_d, emit, flush, brk_clr;
   logic [7:0] tx_buf_d, imr_d;
   cmd_t       cmd;

   uart_cmd_dec u_dec (.cmd_byte(bus_wdata), .cmd(cmd));

   logic       q_ne, q_full, q_push, q_pop;
   logic [7:0] q_head, q_din;

   assign rx_accept = rx_en && !q_full;
   assign q_push    = (rx_push && rx_accept) || rx_break;
   assign q_din     = rx_break ? 8'h00 : rx_byte;
   assign q_pop     = rd_stb && (ofs == OFS_DATA);

   uart_rxq #(.DEPTH(RX_DEPTH), .DATA_W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(q_push), .din(q_din),
      .pop(q_pop), .head(q_head), .not_empty(q_ne), .full(q_full)
   );

   always_comb begin
      ptr_d    = ptr;
      tx_en_d  = tx_en;
      rx_en_d  = rx_en;
      tx_emp_d = tx_emp;
      tx_buf_d = tx_buf;
      imr_d    = imr;
      emit     = 1'b0;
      flush    = 1'b0;
      brk_clr  = 1'b0;
      if (wr_stb) begin
         case (ofs)
            OFS_MODE: ptr_d = 1'b1;
            OFS_CMD: begin
               case (cmd.misc)
                  MISC_PTR_RST: ptr_d = 1'b0;
                  MISC_RX_RST: begin rx_en_d = 1'b0; flush = 1'b1; end
                  MISC_TX_RST: begin tx_en_d = 1'b0; tx_emp_d = 1'b1; end
                  MISC_BRK_CLR: brk_clr = 1'b1;
                  default: ;
               endcase
               case (cmd.tx)
                  DIR_EN: begin
                     tx_en_d = 1'b1;
                     if (!tx_emp_d) begin emit = 1'b1; tx_emp_d = 1'b1; end
                  end
                  DIR_DIS: tx_en_d = 1'b0;
                  default: ;
               endcase
               case (cmd.rx)
                  DIR_EN:  rx_en_d = 1'b1;
                  DIR_DIS: rx_en_d = 1'b0;
                  default: ;
               endcase
            end
            OFS_DATA: begin
               tx_buf_d = bus_wdata;
               if (tx_en) begin emit = 1'b1; tx_emp_d = 1'b1; end
               else tx_emp_d = 1'b0;
            end
            OFS_INT: imr_d = bus_wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode[0]  <= '0;
         mode[1]  <= '0;
         ptr      <= 1'b0;
         tx_en    <= 1'b0;
         rx_en    <= 1'b0;
         tx_emp   <= 1'b1;
         tx_buf   <= '0;
         imr      <= '0;
         brk_flg  <= 1'b0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         if (wr_stb && ofs == OFS_MODE) mode[ptr] <= bus_wdata;
         ptr      <= ptr_d;
         tx_en    <= tx_en_d;
         rx_en    <= rx_en_d;
         tx_emp   <= tx_emp_d;
         tx_buf   <= tx_buf_d;
         imr      <= imr_d;
         if (rx_break)     brk_flg <= 1'b1;
         else if (brk_clr) brk_flg <= 1'b0;
         tx_valid <= emit;
         if (emit) tx_data <= tx_buf_d;
      end
   end

   logic [7:0] stat, isr;
   assign stat = {4'b0000, tx_emp, tx_en, q_full, q_ne};
   assign isr  = {5'b00000, brk_flg, (mode[0][6] ? q_full : q_ne), tx_en};
   assign irq  = |(isr & imr);

   always_comb begin
      case (ofs)
         OFS_MODE: bus_rdata = mode[ptr];
         OFS_STAT: bus_rdata = stat;
         OFS_DATA: bus_rdata = q_head;
         OFS_INT:  bus_rdata = isr;
         OFS_DVH:  bus_rdata = DIV_HI;
         OFS_DVL:  bus_rdata = DIV_LO;
         default:  bus_rdata = 8'h00;
      endcase
   end

   AST_MODE_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ofs == OFS_MODE) |=> ptr); // R2
   AST_EMIT_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_en && tx_emp)); // R6
   AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_emp && !wr_stb) |=> !tx_valid); // R7
   AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ofs == OFS_INT && bus_wdata == 8'h00) |=> !irq); // R8
   AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_break |=> (isr[2] && q_ne)); // R11
endmodule

// File: tb/uart_regctl_tb_top.sv
module uart_regctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic       rx_push = 1'b0, rx_break = 1'b0, rx_accept;
   logic [7:0] rx_byte = '0, tx_data;
   logic       tx_valid, irq;

   always #5 clk = ~clk;

   uart_regctl #(.ADDR_W(8), .RX_DEPTH(4), .DIV_HI(8'h02), .DIV_LO(8'h8B)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_break(rx_break),
      .rx_accept(rx_accept), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   int n_chk = 0, n_bad = 0;

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rxp(input logic [7:0] b);
      @(negedge clk);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   typedef struct packed {
      logic       wr;
      logic [7:0] a;
      logic [7:0] wd;
      logic [7:0] ex;
      logic       txv;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 26;
   // For reads ex is the expected read data; for writes txv/ex give the expected tx strobe and byte.
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h04, 8'h00, 8'h08, 1'b0, 4'd9},   // R9 status after reset
      '{1'b0, 8'h14, 8'h00, 8'h00, 1'b0, 4'd9},   // R9 isr after reset
      '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd9},   // R9 mode after reset
      '{1'b1, 8'h00, 8'h41, 8'h00, 1'b0, 4'd2},   // R2 first mode byte
      '{1'b1, 8'h00, 8'h13, 8'h00, 1'b0, 4'd2},   // R2 second mode byte
      '{1'b0, 8'h00, 8'h00, 8'h13, 1'b0, 4'd2},   // R2 pointer held at second
      '{1'b1, 8'h08, 8'h10, 8'h00, 1'b0, 4'd4},   // R4 pointer reset
      '{1'b0, 8'h00, 8'h00, 8'h41, 1'b0, 4'd4},   // R4
      '{1'b0, 8'h18, 8'h00, 8'h02, 1'b0, 4'd1},   // R1 divider high
      '{1'b0, 8'h5C, 8'h00, 8'h8B, 1'b0, 4'd1},   // R1 upper address bits ignored
      '{1'b0, 8'h24, 8'h00, 8'h00, 1'b0, 4'd1},   // R1 unmapped
      '{1'b1, 8'h04, 8'hFF, 8'h00, 1'b0, 4'd12},  // R12 clock select write
      '{1'b0, 8'h04, 8'h00, 8'h08, 1'b0, 4'd12},  // R12
      '{1'b1, 8'h10, 8'hFF, 8'h00, 1'b0, 4'd12},  // R12 aux write
      '{1'b0, 8'h10, 8'h00, 8'h00, 1'b0, 4'd12},  // R12
      '{1'b1, 8'h0C, 8'hA5, 8'h00, 1'b0, 4'd6},   // R6 byte held, tx off
      '{1'b0, 8'h04, 8'h00, 8'h00, 1'b0, 4'd3},   // R3 empty flag cleared
      '{1'b1, 8'h08, 8'h04, 8'hA5, 1'b1, 4'd7},   // R7 enable releases pending byte
      '{1'b0, 8'h04, 8'h00, 8'h0C, 1'b0, 4'd3},   // R3 ready and empty
      '{1'b1, 8'h0C, 8'h3C, 8'h3C, 1'b1, 4'd6},   // R6 immediate send
      '{1'b0, 8'h14, 8'h00, 8'h01, 1'b0, 4'd8},   // R8 tx interrupt bit
      '{1'b1, 8'h08, 8'h08, 8'h00, 1'b0, 4'd5},   // R5 tx disable
      '{1'b1, 8'h0C, 8'h77, 8'h00, 1'b0, 4'd6},   // R6 pending again
      '{1'b1, 8'h08, 8'h34, 8'h00, 1'b0, 4'd5},   // R5 tx reset then enable: no send
      '{1'b0, 8'h04, 8'h00, 8'h0C, 1'b0, 4'd5},   // R5
      '{1'b1, 8'h08, 8'h0B, 8'h00, 1'b0, 4'd5}    // R5 tx disable, rx reserved
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R9 irq", {7'b0, irq}, 8'h00);
      chk("R9 rx_accept", {7'b0, rx_accept}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) begin
            bwr(VEC[i].a, VEC[i].wd);
            chk($sformatf("R%0d vec%0d tx_valid", VEC[i].rq, i), {7'b0, tx_valid}, {7'b0, VEC[i].txv});
            if (VEC[i].txv)
               chk($sformatf("R%0d vec%0d tx_data", VEC[i].rq, i), tx_data, VEC[i].ex);
         end else begin
            brd(VEC[i].a, d);
            chk($sformatf("R%0d vec%0d rdata", VEC[i].rq, i), d, VEC[i].ex);
         end
      end

      // R5: reserved rx field left receiver off
      brd(8'h04, d); chk("R5 status", d, 8'h08);
      chk("R5 accept", {7'b0, rx_accept}, 8'h00);

      // R10 receive queue order and empty read
      bwr(8'h08, 8'h01);
      chk("R10 accept", {7'b0, rx_accept}, 8'h01);
      rxp(8'h11); rxp(8'h22);
      brd(8'h04, d); chk("R3 ready", d, 8'h09);
      brd(8'h14, d); chk("R8 rx follows full", d, 8'h00);
      brd(8'h0C, d); chk("R10 first", d, 8'h11);
      brd(8'h0C, d); chk("R10 second", d, 8'h22);
      brd(8'h0C, d); chk("R10 empty read", d, 8'h00);
      brd(8'h04, d); chk("R10 drained", d, 8'h08);

      // R11 full queue and break overwrite
      rxp(8'h01); rxp(8'h02); rxp(8'h03); rxp(8'h04);
      brd(8'h04, d); chk("R3 full", d, 8'h0B);
      chk("R10 accept full", {7'b0, rx_accept}, 8'h00);
      brd(8'h14, d); chk("R8 rx int on full", d, 8'h02);
      @(negedge clk); rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
      brd(8'h14, d); chk("R11 break flag", d, 8'h06);
      chk("R8 irq masked", {7'b0, irq}, 8'h00);
      bwr(8'h14, 8'h04);
      chk("R8 irq", {7'b0, irq}, 8'h01);
      brd(8'h0C, d); chk("R11 entry0", d, 8'h01);
      brd(8'h14, d); chk("R8 not full", d, 8'h04);
      brd(8'h0C, d); chk("R11 entry1", d, 8'h02);
      brd(8'h0C, d); chk("R11 entry2", d, 8'h03);
      brd(8'h0C, d); chk("R11 break byte", d, 8'h00);
      brd(8'h04, d); chk("R11 drained", d, 8'h08);

      // R4 break flag clear
      bwr(8'h08, 8'h50);
      brd(8'h14, d); chk("R4 brk clear", d, 8'h00);
      chk("R4 irq low", {7'b0, irq}, 8'h00);

      // R4/R5 flush then receiver enable in one byte
      rxp(8'h5A);
      brd(8'h04, d); chk("R10 push", d, 8'h09);
      bwr(8'h08, 8'h21);
      brd(8'h04, d); chk("R4 flush", d, 8'h08);
      chk("R5 rx re-enabled", {7'b0, rx_accept}, 8'h01);
      bwr(8'h08, 8'h02);
      chk("R5 rx disable", {7'b0, rx_accept}, 8'h00);

      // R6 one-cycle strobe
      bwr(8'h08, 8'h04);
      chk("R7 no pending", {7'b0, tx_valid}, 8'h00);
      bwr(8'h0C, 8'hC3);
      chk("R6 strobe", {7'b0, tx_valid}, 8'h01);
      chk("R6 byte", tx_data, 8'hC3);
      @(negedge clk);
      chk("R6 strobe one cycle", {7'b0, tx_valid}, 8'h00);

      // R9 reset in mid-run
      bwr(8'h14, 8'h01);
      chk("R8 tx irq", {7'b0, irq}, 8'h01);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      brd(8'h04, d); chk("R9 status", d, 8'h08);
      brd(8'h00, d); chk("R9 mode", d, 8'h00);
      brd(8'h14, d); chk("R9 isr", d, 8'h00);
      chk("R9 irq", {7'b0, irq}, 8'h00);
      chk("R9 accept", {7'b0, rx_accept}, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule